// File: doc/BRIEF.md
# Significance-Tracking Result Re-encoder

This unit sits beside a standard binary32 adder or multiplier and carries a significance count through each operation. Each operand holds its precision inside the mantissa. The lowest set mantissa bit is the marker. Every bit above the marker is significant, and every bit below it is noise. A value whose mantissa is all zero (and whose exponent field is neither all zeros nor all ones) carries no significant bits: only its magnitude is known.

The external arithmetic unit works on the operands with their markers cleared and returns an unrounded-at-marker raw binary32 result. The unit decodes both operand precisions and the three exponents. It applies the propagation rule for the selected operation class to get the result precision `r`. It then truncates the raw mantissa to `r` bits and places a new marker directly below them. If no significant bit survives, it produces an error value that keeps only the magnitude.

A single-entry output register holds each result until the consumer takes it.

Top module: `anr_sig_unit`

## Requirements
- R1: For `op_i`=0 (add/sub), `r = eR - max(eA - pA, eB - pB)`. Each `e` is an unbiased exponent and each `p` is a precision. If `1 <= r <= 22`, `res_o` keeps the raw sign, the raw exponent field and raw mantissa bits 22 down to 23-r. It sets bit 22-r and clears every bit below it.
- R2: For `op_i`=1 (mul/div), `r = min(pA, pB)`, and the result is encoded as in R1.
- R3: A computed `r` above 22 is clamped to 22, so the marker lands on mantissa bit 0.
- R4: When `r <= 0`, `res_o` keeps the raw sign and exponent field with an all-zero mantissa, and `err_o` is 1. Whenever `err_o` is 1 the output mantissa is zero.
- R5: An add/sub whose operands are both finite and nonzero but whose raw result is zero yields an error value. Its sign is the raw sign and its magnitude is `2^(F-1)`, where `F = max(eA - pA, eB - pB)`. If `F-1` is below -126, the result is a signed zero with `err_o`=1.
- R6: If either operand is zero, infinity or NaN, `res_o` equals `raw_i` with `err_o`=0. The same holds if the raw result is infinity or NaN, or if the raw result is zero outside the R5 case.
- R7: An operand or raw word with exponent field 0 and a nonzero mantissa uses exponent -126. Its precision is taken from its lowest set mantissa bit, as for normal values.
- R8: An operand's precision is 22 minus the index of its lowest set mantissa bit. A normal operand with a zero mantissa has precision 0.
- R9: `ready_o` is 0 while a result is held. A request accepted on a clock edge (`valid_i` and `ready_o` both high) gives `valid_o`=1 after that edge. `res_o` and `err_o` stay stable until a cycle with `res_ready_i`=1 clears `valid_o`.
- R10: After reset, `valid_o` is 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request valid |
| ready_o | output | 1 | Unit can accept a request |
| op_i | input | 1 | 0 = add/sub rule, 1 = mul/div rule |
| a_i | input | 32 | First tagged operand |
| b_i | input | 32 | Second tagged operand |
| raw_i | input | 32 | Raw result from the external arithmetic unit |
| valid_o | output | 1 | Held result valid |
| res_ready_i | input | 1 | Consumer takes the held result |
| res_o | output | 32 | Re-encoded tagged result |
| err_o | output | 1 | Result mantissa holds no significant bits |

## Verification
The assertions watch several properties on every cycle. They check that an accepted request becomes a held result and that the held result does not move until it is consumed. They check that an error result never carries mantissa bits and that special operands pass through untouched. They also check that the marker produced by the encoder sits exactly where the rule output places it. Only the directed scenarios can show that the numbers are right: the rule arithmetic for each operation class, the clamp, the boundary at `r` = 1 and `r` <= 0, the subnormal exponent and the cancellation magnitude, each compared against hand-derived words.

// File: rtl/anr_sig_pkg.sv
package anr_sig_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } fp_cls_e;

  typedef enum logic {
    OP_ADDSUB = 1'b0,
    OP_MULDIV = 1'b1
  } sig_op_e;
endpackage

// File: rtl/anr_sig_fields.sv
module anr_sig_fields
  import anr_sig_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int SW    = EXP_W + 3
) (
  input  logic [EXP_W-1:0]    fld_i,
  input  logic [MAN_W-1:0]    man_i,
  output fp_cls_e             cls_o,
  output logic signed [SW-1:0] exp_o
);
  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam logic signed [SW-1:0] BIAS_S = SW'(BIAS);
  localparam logic signed [SW-1:0] SUB_E  = SW'(1 - BIAS);

  logic fld_zero, fld_ones, man_zero;
  assign fld_zero = (fld_i == '0);
  assign fld_ones = (fld_i == '1);
  assign man_zero = (man_i == '0);

  always_comb begin
    if (fld_ones)      cls_o = man_zero ? CLS_INF : CLS_NAN;
    else if (fld_zero) cls_o = man_zero ? CLS_ZERO : CLS_SUB;
    else               cls_o = CLS_NORM;
  end

  // subnormals sit at the smallest normal exponent
  assign exp_o = fld_zero ? SUB_E : ($signed({{(SW-EXP_W){1'b0}}, fld_i}) - BIAS_S);
endmodule

// File: rtl/anr_sig_prec.sv
module anr_sig_prec #(
  parameter int MAN_W = 23,
  parameter int PW    = $clog2(MAN_W + 1)
) (
  input  logic [MAN_W-1:0] man_i,
  output logic [PW-1:0]    prec_o
);
  localparam logic [PW-1:0] PMAX = PW'(MAN_W - 1);

  logic [PW-1:0] mark_pos;
  logic          found;

  always_comb begin
    mark_pos = '0;
    found    = 1'b0;
    for (int i = 0; i < MAN_W; i++) begin
      if (!found && man_i[i]) begin
        mark_pos = PW'(i);
        found    = 1'b1;
      end
    end
    prec_o = found ? (PMAX - mark_pos) : '0;
  end
endmodule

// File: rtl/anr_sig_rule.sv
module anr_sig_rule
  import anr_sig_pkg::*;
#(
  parameter int MAN_W = 23,
  parameter int SW    = 11,
  parameter int PW    = 5
) (
  input  sig_op_e             op_i,
  input  logic signed [SW-1:0] exp_a_i,
  input  logic signed [SW-1:0] exp_b_i,
  input  logic signed [SW-1:0] exp_r_i,
  input  logic [PW-1:0]        prec_a_i,
  input  logic [PW-1:0]        prec_b_i,
  output logic signed [SW-1:0] r_o,
  output logic signed [SW-1:0] floor_o
);
  localparam logic signed [SW-1:0] PMAX_S = SW'(MAN_W - 1);

  logic signed [SW-1:0] pa, pb, fa, fb, r_raw;

  assign pa = $signed({{(SW-PW){1'b0}}, prec_a_i});
  assign pb = $signed({{(SW-PW){1'b0}}, prec_b_i});
  // weight of the lowest significant bit of each operand
  assign fa = exp_a_i - pa;
  assign fb = exp_b_i - pb;
  assign floor_o = (fa > fb) ? fa : fb;

  always_comb begin
    if (op_i == OP_ADDSUB) r_raw = exp_r_i - floor_o;
    else                   r_raw = (pa < pb) ? pa : pb;
    r_o = (r_raw > PMAX_S) ? PMAX_S : r_raw;
  end
endmodule

// File: rtl/anr_sig_encode.sv
module anr_sig_encode
  import anr_sig_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int SW    = EXP_W + 3,
  parameter int W     = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]         raw_i,
  input  sig_op_e              op_i,
  input  fp_cls_e              cls_a_i,
  input  fp_cls_e              cls_b_i,
  input  fp_cls_e              cls_r_i,
  input  logic signed [SW-1:0] r_i,
  input  logic signed [SW-1:0] floor_i,
  output logic [W-1:0]         res_o,
  output logic                 err_o,
  output logic                 pass_o
);
  localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
  localparam logic signed [SW-1:0] BIAS_S = SW'(BIAS);
  localparam logic signed [SW-1:0] EMIN_S = SW'(1 - BIAS);
  localparam logic signed [SW-1:0] PMAX_S = SW'(MAN_W - 1);
  localparam logic signed [SW-1:0] ONE_S  = SW'(1);

  logic                 spec_a, spec_b, raw_spec, cancel;
  logic signed [SW-1:0] can_e, can_fld, shamt;
  logic [MAN_W-1:0]     keep_mask, mark;

  assign spec_a   = (cls_a_i == CLS_ZERO) || (cls_a_i == CLS_INF) || (cls_a_i == CLS_NAN);
  assign spec_b   = (cls_b_i == CLS_ZERO) || (cls_b_i == CLS_INF) || (cls_b_i == CLS_NAN);
  assign raw_spec = (cls_r_i == CLS_INF) || (cls_r_i == CLS_NAN);
  assign cancel   = (op_i == OP_ADDSUB) && !spec_a && !spec_b && (cls_r_i == CLS_ZERO);
  assign pass_o   = spec_a || spec_b || raw_spec || ((cls_r_i == CLS_ZERO) && !cancel);

  assign can_e   = floor_i - ONE_S;
  assign can_fld = can_e + BIAS_S;
  assign shamt   = PMAX_S - r_i;
  assign keep_mask = {MAN_W{1'b1}} << (shamt + ONE_S);
  assign mark      = {{(MAN_W-1){1'b0}}, 1'b1} << shamt;

  always_comb begin
    res_o = raw_i;
    err_o = 1'b0;
    if (pass_o) begin
      res_o = raw_i;
    end else if (cancel) begin
      err_o = 1'b1;
      if (can_e < EMIN_S) res_o = {raw_i[W-1], {(W-1){1'b0}}};
      else                res_o = {raw_i[W-1], can_fld[EXP_W-1:0], {MAN_W{1'b0}}};
    end else if (r_i <= 0) begin
      err_o = 1'b1;
      res_o = {raw_i[W-1:MAN_W], {MAN_W{1'b0}}};
    end else begin
      res_o = {raw_i[W-1:MAN_W], (raw_i[MAN_W-1:0] & keep_mask) | mark};
    end
  end
endmodule

// File: rtl/anr_sig_unit.sv
module anr_sig_unit
  import anr_sig_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  output logic                     ready_o,
  input  logic                     op_i,
  input  logic [EXP_W+MAN_W:0]     a_i,
  input  logic [EXP_W+MAN_W:0]     b_i,
  input  logic [EXP_W+MAN_W:0]     raw_i,
  output logic                     valid_o,
  input  logic                     res_ready_i,
  output logic [EXP_W+MAN_W:0]     res_o,
  output logic                     err_o
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int SW = EXP_W + 3;
  localparam int PW = $clog2(MAN_W + 1);
  localparam int NW = 3;  // a, b, raw
  localparam logic signed [SW-1:0] PMAX_S = SW'(MAN_W - 1);

  sig_op_e              op;
  logic [W-1:0]         words [NW];
  fp_cls_e              cls   [NW];
  logic signed [SW-1:0] expv  [NW];
  logic [PW-1:0]        prec  [2];
  logic signed [SW-1:0] rule_r, rule_floor;
  logic [W-1:0]         enc_res;
  logic                 enc_err, enc_pass, accept;
  logic                 unused_sign;

  assign op       = sig_op_e'(op_i);
  assign words[0] = a_i;
  assign words[1] = b_i;
  assign words[2] = raw_i;
  assign unused_sign = a_i[W-1] ^ b_i[W-1];

  for (genvar g = 0; g < NW; g++) begin : g_fields
    anr_sig_fields #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SW(SW)) u_fields (
      .fld_i (words[g][W-2:MAN_W]),
      .man_i (words[g][MAN_W-1:0]),
      .cls_o (cls[g]),
      .exp_o (expv[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_prec
    anr_sig_prec #(.MAN_W(MAN_W), .PW(PW)) u_prec (
      .man_i  (words[g][MAN_W-1:0]),
      .prec_o (prec[g])
    );
  end

  anr_sig_rule #(.MAN_W(MAN_W), .SW(SW), .PW(PW)) u_rule (
    .op_i     (op),
    .exp_a_i  (expv[0]),
    .exp_b_i  (expv[1]),
    .exp_r_i  (expv[2]),
    .prec_a_i (prec[0]),
    .prec_b_i (prec[1]),
    .r_o      (rule_r),
    .floor_o  (rule_floor)
  );

  anr_sig_encode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SW(SW), .W(W)) u_enc (
    .raw_i   (raw_i),
    .op_i    (op),
    .cls_a_i (cls[0]),
    .cls_b_i (cls[1]),
    .cls_r_i (cls[2]),
    .r_i     (rule_r),
    .floor_i (rule_floor),
    .res_o   (enc_res),
    .err_o   (enc_err),
    .pass_o  (enc_pass)
  );

  // single-entry hold register
  assign ready_o = !valid_o;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      err_o   <= 1'b0;
    end else if (accept) begin
      valid_o <= 1'b1;
      res_o   <= enc_res;
      err_o   <= enc_err;
    end else if (res_ready_i) begin
      valid_o <= 1'b0;
    end
  end

  logic [MAN_W-1:0] enc_man, lsb_iso, mark_ref;
  assign enc_man  = enc_res[MAN_W-1:0];
  assign lsb_iso  = enc_man & (~enc_man + 1'b1);
  assign mark_ref = {{(MAN_W-1){1'b0}}, 1'b1} << (PMAX_S - rule_r);

  assert_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !res_ready_i) |=> (valid_o && $stable(res_o) && $stable(err_o)));
  assert_err_mant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && err_o) |-> (res_o[MAN_W-1:0] == '0));
  assert_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && enc_pass) |=> (res_o == $past(raw_i) && !err_o));
  assert_mark_pos_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !enc_pass && !enc_err) |-> (lsb_iso == mark_ref));
endmodule

// File: tb/anr_sig_unit_tb_top.sv
module anr_sig_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic        op_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, raw_i = '0;
  logic        valid_o;
  logic        res_ready_i = 1'b0;
  logic [31:0] res_o;
  logic        err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  anr_sig_unit dut_i (
    .clk_i, .rst_ni, .valid_i, .ready_o, .op_i, .a_i, .b_i, .raw_i,
    .valid_o, .res_ready_i, .res_o, .err_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] raw, input logic [31:0] exp_res,
                        input logic exp_err, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; raw_i = raw; res_ready_i = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o === 1'b1, {tag, " valid"}, 32'(valid_o), 32'd1);
    chk(res_o === exp_res, {tag, " res"}, res_o, exp_res);
    chk(err_o === exp_err, {tag, " err"}, 32'(err_o), 32'(exp_err));
    res_ready_i = 1'b1;
    @(negedge clk_i);
    res_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    chk(valid_o === 1'b0, "R10 valid_o", 32'(valid_o), 32'd0);
    chk(ready_o === 1'b1, "R10 ready_o", 32'(ready_o), 32'd1);
  endtask

  task automatic t_add_rule();
    // R1: eA=0 pA=22, eB=0 pB=10, eR=1 -> r=11
    run_op(1'b0, 32'h3F800001, 32'h3F801000, 32'h40123457, 32'h40123800, 1'b0, "R1 add");
  endtask

  task automatic t_clamp();
    // R3: floor -22, eR=1 -> r=23 clamped to 22
    run_op(1'b0, 32'h3F800001, 32'h30800001, 32'h40012344, 32'h40012345, 1'b0, "R3 clamp");
  endtask

  task automatic t_mul_rule();
    run_op(1'b1, 32'h3F800001, 32'h40401000, 32'h40400FFF, 32'h40401000, 1'b0, "R2 mul min");
    run_op(1'b1, 32'h3FA00000, 32'h3F800001, 32'h40555555, 32'h40600000, 1'b0, "R2 r=1");
  endtask

  task automatic t_error_value();
    // R4: floor 8, eR=5 -> r=-3
    run_op(1'b0, 32'h3F800001, 32'h44900000, 32'h42012345, 32'h42000000, 1'b1, "R4 add r<0");
    run_op(1'b1, 32'h3F800001, 32'h40000000, 32'h40000000, 32'h40000000, 1'b1, "R4 mul r=0");
  endtask

  task automatic t_prec_decode();
    // R8: marker at bit 22 -> precision 0
    run_op(1'b1, 32'h3FC00000, 32'h3F800001, 32'h3FC00000, 32'h3F800000, 1'b1, "R8 prec0");
  endtask

  task automatic t_cancel();
    run_op(1'b0, 32'h62800001, 32'h44800001, 32'h62800000, 32'h62800001, 1'b0, "R5 big+small");
    run_op(1'b0, 32'h62800001, 32'hE2800001, 32'h00000000, 32'h57000000, 1'b1, "R5 cancel 2^47");
    run_op(1'b0, 32'h62800001, 32'hE2800001, 32'h80000000, 32'hD7000000, 1'b1, "R5 cancel sign");
    run_op(1'b0, 32'h03800001, 32'h83800001, 32'h00000000, 32'h00000000, 1'b1, "R5 cancel tiny");
  endtask

  task automatic t_special();
    run_op(1'b0, 32'h00000000, 32'h3F800001, 32'h3F800000, 32'h3F800000, 1'b0, "R6 zero op");
    run_op(1'b1, 32'h7F800000, 32'h3F800001, 32'h7F800000, 32'h7F800000, 1'b0, "R6 inf op");
    run_op(1'b0, 32'h3F800001, 32'h3F801000, 32'h7FC00000, 32'h7FC00000, 1'b0, "R6 nan raw");
    run_op(1'b1, 32'h03800001, 32'h03800001, 32'h00000000, 32'h00000000, 1'b0, "R6 mul zero raw");
  endtask

  task automatic t_subnormal();
    // R7: sub pA=14 e=-126, pB=22 e=-120, eR=-120 -> r=20
    run_op(1'b0, 32'h00000100, 32'h03800001, 32'h03812345, 32'h03812344, 1'b0, "R7 subnormal");
  endtask

  task automatic t_handshake();
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 1'b0; a_i = 32'h3F800001; b_i = 32'h3F801000; raw_i = 32'h40123457;
    res_ready_i = 1'b0;
    @(negedge clk_i);
    chk(valid_o === 1'b1, "R9 accept", 32'(valid_o), 32'd1);
    // new request offered while holding must be ignored
    a_i = 32'h00000000; raw_i = 32'h11111111;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk(ready_o === 1'b0, "R9 ready low", 32'(ready_o), 32'd0);
      chk(res_o === 32'h40123800, "R9 hold", res_o, 32'h40123800);
    end
    valid_i = 1'b0; res_ready_i = 1'b1;
    @(negedge clk_i);
    res_ready_i = 1'b0;
    chk(valid_o === 1'b0, "R9 consume", 32'(valid_o), 32'd0);
    chk(ready_o === 1'b1, "R9 ready back", 32'(ready_o), 32'd1);
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R9 no stale capture", 32'(valid_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_add_rule();
    t_clamp();
    t_mul_rule();
    t_error_value();
    t_prec_decode();
    t_cancel();
    t_special();
    t_subnormal();
    t_handshake();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule